// File: doc/BRIEF.md
# Wait-Hint Trap Arbiter

This block settles the outcome of a wait-for-event or wait-for-interrupt hint. When either hint is strobed, it produces one of five mutually exclusive results. The hint can complete at once. The core can enter a low-power wait. Or the hint can trap to the handler at exception level 1, 2 or 3. A trap is chosen from a per-level enable vector, and only the levels whose checks apply at the current exception level are considered. For wait-for-interrupt the vector used is `wfi_trap_en`; for wait-for-event it is `wfe_trap_en`.

A one-bit event latch remembers pending events. An external event or a local send-event sets it. A wait-for-event that finds it set consumes it and completes without trapping. A broadcast send-event does not touch the latch; it raises a one-cycle pulse for the rest of the system. Once the block is in the wait state, it stays there until its wake condition arrives, then reports completion for one cycle. The actual low-power sequencing and the exception entry are handled elsewhere.

All control pins are plain single-cycle strobes or levels. There is no data stream, so there is no valid/ready handshake. Results are registered and appear in the cycle after the strobe.

Top module: `wfx_trap_arbiter`

## Requirements
- R1: A synchronous active-low `rst_n` clears `result`, `event_reg` and `sev_pulse` to 0 and returns the block to idle.
- R2: In idle, `wfe_i` with `event_reg` set gives `result` = 5'b00001 (complete) in the next cycle. It also clears `event_reg`, whatever the trap enables say.
- R3: In idle, `wfi_i` with `irq_pending` high gives `result` = 5'b00001 in the next cycle, whatever the trap enables say.
- R4: Trap enable bit 0 (EL1 trap) is honoured only when `cur_el` is 0. A trap taken to EL1 gives `result` = 5'b00100.
- R5: Trap enable bit 1 (EL2 trap) is honoured only when `cur_el` is 0 or 1, `el2_on` is 1 and `host_mode` is 0. A trap taken to EL2 gives `result` = 5'b01000.
- R6: Trap enable bit 2 (EL3 trap) is honoured only when `el3_present` is 1 and `cur_el` is not 3. A trap taken to EL3 gives `result` = 5'b10000.
- R7: When several traps are honoured, only the lowest target level is reported (EL1 before EL2 before EL3).
- R8: A hint that neither completes nor traps gives `result` = 5'b00010 (wait). This value is held every cycle while waiting, and new `wfe_i`/`wfi_i` strobes are ignored while waiting.
- R9: A wait entered by wait-for-event ends once `event_reg` is set: `result` = 5'b00001 for one cycle, and `event_reg` is cleared. A wait entered by wait-for-interrupt ends in the cycle after `irq_pending` is sampled high, and it ignores events.
- R10: `ext_event` or `sevl_i` sets `event_reg` in the next cycle. This set wins over a same-cycle consumption. A wait-for-interrupt leaves `event_reg` unchanged.
- R11: `sev_i` raises `sev_pulse` for exactly the next cycle and does not change `event_reg`.
- R12: `result` never has more than one bit set. When `wfe_i` and `wfi_i` are strobed together, the hint is treated as wait-for-event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfe_i | input | 1 | Wait-for-event hint strobe |
| wfi_i | input | 1 | Wait-for-interrupt hint strobe |
| sev_i | input | 1 | Broadcast send-event strobe |
| sevl_i | input | 1 | Local send-event strobe |
| cur_el | input | 2 | Current exception level |
| el2_on | input | 1 | EL2 enabled |
| host_mode | input | 1 | Running in host mode |
| el3_present | input | 1 | EL3 implemented |
| wfe_trap_en | input | 3 | Wait-for-event trap enables, bit n-1 = trap to ELn |
| wfi_trap_en | input | 3 | Wait-for-interrupt trap enables, bit n-1 = trap to ELn |
| irq_pending | input | 1 | An interrupt is pending |
| ext_event | input | 1 | External event arrival |
| result | output | 5 | One-hot: bit0 complete, bit1 wait, bit2..4 trap to EL1..EL3 |
| event_reg | output | 1 | Event latch value |
| sev_pulse | output | 1 | One-cycle send-event broadcast |

## Verification
The bench uses the package defaults: a two-bit exception level and three trap targets. With these values every combination of current level, EL2 enable, host mode and EL3 presence can be reached from the stimulus table. Each table row drives the unused hint's enable vector with the complement of the active one, so a wrong vector choice changes the outcome. Directed cases cover the race between setting and consuming the event latch, strobes that arrive while waiting, and a reset taken in the middle of a wait.

// File: rtl/wfx_pkg.sv
package wfx_pkg;
  localparam int EL_W     = 2;
  localparam int TOP_EL   = (1 << EL_W) - 1;
  localparam int N_TRAP   = TOP_EL;
  localparam int HYP_EL   = 2;
  localparam int RES_W    = N_TRAP + 2;
  localparam int RES_DONE = 0;
  localparam int RES_WAIT = 1;
  localparam int RES_TRAP0 = 2;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_EVT = 2'd1,
    ST_WAIT_IRQ = 2'd2
  } wait_st_t;

  // A trap to level lvl is considered only from a lower level, with
  // extra gating for the hypervisor and monitor levels.
  function automatic logic trap_applies(input int lvl,
                                        input logic [EL_W-1:0] cur,
                                        input logic el2_on,
                                        input logic host_mode,
                                        input logic el3_present);
    logic ok;
    ok = (int'(cur) < lvl);
    if (lvl == HYP_EL) ok = ok & el2_on & ~host_mode;
    if (lvl == TOP_EL) ok = ok & el3_present;
    return ok;
  endfunction
endpackage

// File: rtl/wfx_trap_select.sv
module wfx_trap_select
  import wfx_pkg::*;
(
  input  logic [EL_W-1:0]   cur_el,
  input  logic              el2_on,
  input  logic              host_mode,
  input  logic              el3_present,
  input  logic [N_TRAP-1:0] trap_en,
  output logic              trap_hit,
  output logic [N_TRAP-1:0] trap_oh
);
  logic [N_TRAP-1:0] armed;

  for (genvar g = 1; g <= N_TRAP; g++) begin : g_lvl
    assign armed[g-1] = trap_en[g-1] &
                        trap_applies(g, cur_el, el2_on, host_mode, el3_present);
  end

  // Lowest armed level wins.
  assign trap_oh  = armed & ~(armed - N_TRAP'(1));
  assign trap_hit = |armed;
endmodule

// File: rtl/wfx_event_latch.sv
module wfx_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic evt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     evt_o <= 1'b0;
    else if (set_i) evt_o <= 1'b1;
    else if (clr_i) evt_o <= 1'b0;
  end
endmodule

// File: rtl/wfx_wait_fsm.sv
module wfx_wait_fsm
  import wfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wfe_i,
  input  logic              wfi_i,
  input  logic              event_reg,
  input  logic              irq_pending,
  input  logic              trap_hit,
  input  logic [N_TRAP-1:0] trap_oh,
  output logic              consume,
  output logic [RES_W-1:0]  result
);
  wait_st_t         st, nxt_st;
  logic [RES_W-1:0] nxt_res;

  always_comb begin
    nxt_st  = st;
    nxt_res = '0;
    consume = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (wfe_i) begin
          if (event_reg) begin
            nxt_res[RES_DONE] = 1'b1;
            consume = 1'b1;
          end else if (trap_hit) begin
            nxt_res[RES_W-1:RES_TRAP0] = trap_oh;
          end else begin
            nxt_st = ST_WAIT_EVT;
            nxt_res[RES_WAIT] = 1'b1;
          end
        end else if (wfi_i) begin
          if (irq_pending) begin
            nxt_res[RES_DONE] = 1'b1;
          end else if (trap_hit) begin
            nxt_res[RES_W-1:RES_TRAP0] = trap_oh;
          end else begin
            nxt_st = ST_WAIT_IRQ;
            nxt_res[RES_WAIT] = 1'b1;
          end
        end
      end
      ST_WAIT_EVT: begin
        if (event_reg) begin
          nxt_st = ST_IDLE;
          nxt_res[RES_DONE] = 1'b1;
          consume = 1'b1;
        end else begin
          nxt_res[RES_WAIT] = 1'b1;
        end
      end
      ST_WAIT_IRQ: begin
        if (irq_pending) begin
          nxt_st = ST_IDLE;
          nxt_res[RES_DONE] = 1'b1;
        end else begin
          nxt_res[RES_WAIT] = 1'b1;
        end
      end
      default: nxt_st = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      result <= '0;
    end else begin
      st     <= nxt_st;
      result <= nxt_res;
    end
  end
endmodule

// File: rtl/wfx_trap_arbiter.sv
module wfx_trap_arbiter
  import wfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wfe_i,
  input  logic              wfi_i,
  input  logic              sev_i,
  input  logic              sevl_i,
  input  logic [EL_W-1:0]   cur_el,
  input  logic              el2_on,
  input  logic              host_mode,
  input  logic              el3_present,
  input  logic [N_TRAP-1:0] wfe_trap_en,
  input  logic [N_TRAP-1:0] wfi_trap_en,
  input  logic              irq_pending,
  input  logic              ext_event,
  output logic [RES_W-1:0]  result,
  output logic              event_reg,
  output logic              sev_pulse
);
  logic [N_TRAP-1:0] sel_en;
  logic [N_TRAP-1:0] trap_oh;
  logic              trap_hit;
  logic              consume;

  // Wait-for-event takes precedence when both strobes arrive.
  assign sel_en = wfe_i ? wfe_trap_en : wfi_trap_en;

  wfx_trap_select u_sel (
    .cur_el      (cur_el),
    .el2_on      (el2_on),
    .host_mode   (host_mode),
    .el3_present (el3_present),
    .trap_en     (sel_en),
    .trap_hit    (trap_hit),
    .trap_oh     (trap_oh)
  );

  wfx_wait_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wfe_i       (wfe_i),
    .wfi_i       (wfi_i),
    .event_reg   (event_reg),
    .irq_pending (irq_pending),
    .trap_hit    (trap_hit),
    .trap_oh     (trap_oh),
    .consume     (consume),
    .result      (result)
  );

  wfx_event_latch u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ext_event | sevl_i),
    .clr_i (consume),
    .evt_o (event_reg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sev_pulse <= 1'b0;
    else        sev_pulse <= sev_i;
  end
endmodule

// File: rtl/wfx_trap_arbiter_chk.sv
module wfx_trap_arbiter_chk
  import wfx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wfe_i,
  input logic             wfi_i,
  input logic             sev_i,
  input logic             sevl_i,
  input logic             irq_pending,
  input logic             ext_event,
  input logic [RES_W-1:0] result,
  input logic             event_reg,
  input logic             sev_pulse
);
  a_r12_result_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(result));

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (result == '0) && !event_reg && !sev_pulse);

  a_r2_event_completes: assert property (@(posedge clk) disable iff (!rst_n)
    wfe_i && event_reg && !result[RES_WAIT] |=> result[RES_DONE]);

  a_r3_irq_completes: assert property (@(posedge clk) disable iff (!rst_n)
    wfi_i && !wfe_i && irq_pending && !result[RES_WAIT] |=> result[RES_DONE]);

  a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    result[RES_WAIT] && !event_reg && !irq_pending |=> result[RES_WAIT]);

  a_r10_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ext_event || sevl_i |=> event_reg);

  a_r10_wfi_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
    wfi_i && !wfe_i && !ext_event && !sevl_i && !result[RES_WAIT]
    |=> event_reg == $past(event_reg));

  a_r11_sev_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sev_i |=> sev_pulse);

  a_r11_sev_origin: assert property (@(posedge clk) disable iff (!rst_n)
    sev_pulse |-> $past(sev_i));
endmodule

bind wfx_trap_arbiter wfx_trap_arbiter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wfe_i       (wfe_i),
  .wfi_i       (wfi_i),
  .sev_i       (sev_i),
  .sevl_i      (sevl_i),
  .irq_pending (irq_pending),
  .ext_event   (ext_event),
  .result      (result),
  .event_reg   (event_reg),
  .sev_pulse   (sev_pulse)
);

// File: tb/wfx_trap_arbiter_test.sv
`timescale 1ns/1ps
module wfx_trap_arbiter_test;
  localparam logic [4:0] D  = 5'b00001;
  localparam logic [4:0] W  = 5'b00010;
  localparam logic [4:0] T1 = 5'b00100;
  localparam logic [4:0] T2 = 5'b01000;
  localparam logic [4:0] T3 = 5'b10000;
  localparam int NV = 16;

  // {is_wfi, el, el2_on, host, el3_present, trap_en, irq, expected}
  localparam logic [14:0] VECS [NV] = '{
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 3'b000, 1'b0, W },
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 3'b111, 1'b0, T1},
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 3'b110, 1'b0, T2},
    {1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 3'b110, 1'b0, T3},
    {1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 3'b001, 1'b0, W },
    {1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 3'b011, 1'b0, T2},
    {1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 3'b010, 1'b0, W },
    {1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 3'b011, 1'b0, W },
    {1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 3'b100, 1'b0, T3},
    {1'b0, 2'd3, 1'b1, 1'b0, 1'b1, 3'b111, 1'b0, W },
    {1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 3'b100, 1'b0, W },
    {1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 3'b111, 1'b1, D },
    {1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 3'b100, 1'b0, T3},
    {1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 3'b101, 1'b0, T3},
    {1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 3'b000, 1'b0, W },
    {1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 3'b010, 1'b0, W }
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wfe_i = 1'b0, wfi_i = 1'b0, sev_i = 1'b0, sevl_i = 1'b0;
  logic [1:0] cur_el = '0;
  logic       el2_on = 1'b0, host_mode = 1'b0, el3_present = 1'b0;
  logic [2:0] wfe_trap_en = '0, wfi_trap_en = '0;
  logic       irq_pending = 1'b0, ext_event = 1'b0;
  logic [4:0] result;
  logic       event_reg, sev_pulse;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wfx_trap_arbiter uut (
    .clk(clk), .rst_n(rst_n), .wfe_i(wfe_i), .wfi_i(wfi_i), .sev_i(sev_i),
    .sevl_i(sevl_i), .cur_el(cur_el), .el2_on(el2_on), .host_mode(host_mode),
    .el3_present(el3_present), .wfe_trap_en(wfe_trap_en),
    .wfi_trap_en(wfi_trap_en), .irq_pending(irq_pending),
    .ext_event(ext_event), .result(result), .event_reg(event_reg),
    .sev_pulse(sev_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] e);
    case (e)
      D:       return "R3";
      T1:      return "R4";
      T2:      return "R5";
      T3:      return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_ctx(input logic [1:0] el, input logic e2, input logic h, input logic e3);
    cur_el = el; el2_on = e2; host_mode = h; el3_present = e3;
  endtask

  // Leave a wait entered by wait-for-interrupt.
  task automatic wake_irq();
    irq_pending = 1'b1;
    tick();
    check("R9 irq wake done", result, D);
    irq_pending = 1'b0;
    tick();
    check("R9 done lasts one cycle", result, 5'b0);
  endtask

  // Leave a wait entered by wait-for-event.
  task automatic wake_evt();
    ext_event = 1'b1;
    tick();
    ext_event = 1'b0;
    check("R9 still waiting while latch fills", result, W);
    check("R10 ext event sets latch", event_reg, 1'b1);
    tick();
    check("R9 event wake done", result, D);
    check("R9 event consumed on wake", event_reg, 1'b0);
    tick();
    check("R9 done lasts one cycle", result, 5'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R1 reset result", result, 5'b0);
    check("R1 reset event", event_reg, 1'b0);
    check("R1 reset sev", sev_pulse, 1'b0);
    rst_n = 1'b1;
    tick();

    // Table walk with the event latch empty.
    for (int i = 0; i < NV; i++) begin
      logic       v_wfi;
      logic [2:0] v_en;
      logic [4:0] v_exp;
      v_wfi = VECS[i][14];
      v_en  = VECS[i][8:6];
      v_exp = VECS[i][4:0];
      set_ctx(VECS[i][13:12], VECS[i][11], VECS[i][10], VECS[i][9]);
      irq_pending = VECS[i][5];
      wfe_trap_en = v_wfi ? ~v_en : v_en;
      wfi_trap_en = v_wfi ? v_en : ~v_en;
      wfe_i = ~v_wfi;
      wfi_i = v_wfi;
      tick();
      wfe_i = 1'b0; wfi_i = 1'b0; irq_pending = 1'b0;
      check(tag_of(v_exp), result, v_exp);
      tick();
      if (v_exp == W) begin
        check("R8 wait held", result, W);
        if (v_wfi) wake_irq(); else wake_evt();
      end else begin
        check("R12 single-cycle outcome", result, 5'b0);
      end
    end

    // R7: all three traps armed, lowest level reported.
    set_ctx(2'd0, 1'b1, 1'b0, 1'b1);
    wfe_trap_en = 3'b111; wfi_trap_en = 3'b000;
    wfe_i = 1'b1; tick(); wfe_i = 1'b0;
    check("R7 priority EL1 first", result, T1);
    tick();

    // R10: local send-event sets latch; R11 pulse absent.
    sevl_i = 1'b1; tick(); sevl_i = 1'b0;
    check("R10 sevl sets latch", event_reg, 1'b1);
    check("R11 no pulse from sevl", sev_pulse, 1'b0);

    // R10: wait-for-interrupt with irq leaves latch alone.
    irq_pending = 1'b1; wfi_i = 1'b1; tick(); wfi_i = 1'b0; irq_pending = 1'b0;
    check("R3 wfi with irq completes", result, D);
    check("R10 wfi keeps latch", event_reg, 1'b1);
    tick();

    // R2: consume the event despite armed traps.
    wfe_i = 1'b1; tick(); wfe_i = 1'b0;
    check("R2 event completes wfe", result, D);
    check("R2 event cleared", event_reg, 1'b0);
    tick();

    // R11: broadcast pulse.
    sev_i = 1'b1; tick(); sev_i = 1'b0;
    check("R11 sev pulse high", sev_pulse, 1'b1);
    check("R11 sev leaves latch", event_reg, 1'b0);
    tick();
    check("R11 sev pulse one cycle", sev_pulse, 1'b0);

    // R10: set wins over consumption in the same cycle.
    sevl_i = 1'b1; tick(); sevl_i = 1'b0;
    wfe_i = 1'b1; ext_event = 1'b1; tick(); wfe_i = 1'b0; ext_event = 1'b0;
    check("R2 wfe completes on latch", result, D);
    check("R10 set beats consume", event_reg, 1'b1);
    wfe_i = 1'b1; tick(); wfe_i = 1'b0;
    check("R10 second wfe consumes", event_reg, 1'b0);
    tick();

    // R8/R9: strobes and events ignored by a wait-for-interrupt wait.
    set_ctx(2'd3, 1'b1, 1'b0, 1'b1);
    wfi_trap_en = 3'b000;
    wfi_i = 1'b1; tick(); wfi_i = 1'b0;
    check("R8 wfi enters wait", result, W);
    set_ctx(2'd0, 1'b1, 1'b0, 1'b1);
    wfe_trap_en = 3'b111;
    wfe_i = 1'b1; tick(); wfe_i = 1'b0;
    check("R8 wfe ignored while waiting", result, W);
    sevl_i = 1'b1; tick(); sevl_i = 1'b0;
    tick();
    check("R9 wfi wait ignores event", result, W);
    check("R10 latch set during wait", event_reg, 1'b1);
    wake_irq();
    wfe_i = 1'b1; tick(); wfe_i = 1'b0;
    check("R2 drain latch", event_reg, 1'b0);
    tick();

    // R12: both strobes together act as wait-for-event.
    wfe_trap_en = 3'b001; wfi_trap_en = 3'b000; irq_pending = 1'b1;
    wfe_i = 1'b1; wfi_i = 1'b1; tick();
    wfe_i = 1'b0; wfi_i = 1'b0; irq_pending = 1'b0;
    check("R12 wfe wins over wfi", result, T1);
    tick();

    // R1: reset in the middle of a wait.
    wfe_trap_en = 3'b000;
    wfe_i = 1'b1; tick(); wfe_i = 1'b0;
    check("R8 wfe enters wait", result, W);
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    check("R1 reset leaves wait", result, 5'b0);
    sevl_i = 1'b1; tick(); sevl_i = 1'b0;
    tick();
    check("R1 idle after reset ignores latch", result, 5'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule